// File: doc/BRIEF.md
# Tiled Crossbar Matrix-Vector Engine

This block computes a square matrix-vector product the way an emulated resistive crossbar would. Each matrix column is a separate dot-product. K parallel cell lanes each form one element-wise product. When the vector has more than K rows, the engine makes several K-wide passes over the same column and folds them into an accumulator through an adder tree. Each stored weight is a differential pair of conductance codes plus a signed noise code. The effective cell value is the positive conductance minus the negative conductance plus the noise.

A run starts with a `start` pulse while idle. The engine then takes N vector elements on a ready/valid stream, and these act as the row voltages. It next reads one memory word per pass, sequentially, column by column. After the last pass of a column, the summed current is multiplied by a programmable scale factor and saturated. An optional rectifier then clamps negative results to zero, and the value is presented as a one-cycle result strobe. The scale and rectifier settings are sampled at `start`. Rows beyond N in the final pass act as zero-conductance padding.

The controller is a five-state machine:
- `ST_IDLE`: goes to `ST_LOAD` on `start`.
- `ST_LOAD`: goes to `ST_FETCH` once the N-th element is accepted.
- `ST_FETCH`: issues a read, then always goes to `ST_MAC`.
- `ST_MAC`: consumes the read data. It returns to `ST_FETCH` if passes remain for the column, and otherwise goes to `ST_EMIT`.
- `ST_EMIT`: registers the column result. It goes to `ST_FETCH` for the next column, or to `ST_IDLE` after the last column.

The accumulator is twice the product width and saturates.

Top module: `xbar_mvm_engine`

## Requirements
- R1: A `start` pulse in idle moves the engine to vector loading. `vec_ready` stays high until N elements have been accepted, one on each clock edge where `vec_valid` and `vec_ready` are both high. The elements are taken as rows 0 to N-1 in arrival order.
- R2: Each column takes exactly P = ceil(N/K) memory reads, and `mem_req` is never high on two consecutive cycles. Over a run, `mem_addr` steps through 0, 1, 2, ... so that word col*P+pass is read. `mem_rdata` is sampled one cycle after `mem_req`.
- R3: Each word holds K lanes of 3*GW bits, and lane i sits at bits [i*3*GW +: 3*GW]. Within a lane, the unsigned positive conductance is in the top GW bits, the unsigned negative conductance is in the middle GW bits, and the two's-complement noise is in the low GW bits. The cell value is positive minus negative plus noise.
- R4: A lane whose row index pass*K+lane is N or more contributes zero, whatever its memory bits hold.
- R5: The raw column sum is the sum over rows r of vector[r] times the cell value of (column, r). The accumulator restarts for each column, so nothing carries over from a previous column or run.
- R6: The result is the column sum times the unsigned scale sampled at `start`, saturated to the signed range of `out_data`.
- R7: When `relu_en` was high at `start`, every negative result is output as 0.
- R8: Results appear in column order, one per column, each with a single-cycle `out_valid`. `out_last` is high only with the final column's result, and `busy` falls on that same cycle.
- R9: A `start` pulse while `busy` is high has no effect: the run's results are unchanged and the engine is idle afterwards.
- R10: After reset, `busy`, `vec_ready`, `mem_req` and `out_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| relu_en | input | 1 | Rectify results of this run (sampled at start) |
| scale | input | SW | Unsigned output scale (sampled at start) |
| busy | output | 1 | High from start until last result |
| vec_valid | input | 1 | Vector element offered |
| vec_data | input | VW | Signed vector element (row voltage) |
| vec_ready | output | 1 | Engine accepts vector elements |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADW | Word address, col*P+pass |
| mem_rdata | input | K*3*GW | Read data, one cycle after request |
| out_valid | output | 1 | Column result strobe |
| out_data | output | 2*(VW+GW+2) | Signed column result |
| out_last | output | 1 | Final column marker |

## Verification
If the pass counter or the address counter is corrupted, it shows up at the memory port within one column: the bench checks every `mem_addr`, and it checks the read count between result strobes. A wrong lane decode, a missing padding mask, or an accumulator that does not restart produces a wrong `out_data` at the first affected column's strobe. The random memory contents make such errors visible on nearly every column. A corrupted state register breaks the strobe pattern or the timing of the `busy` fall, and the bound properties catch this on the cycle it happens.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FETCH,
        ST_MAC,
        ST_EMIT
    } xbar_state_e;

endpackage

// File: rtl/xbar_cell.sv
// One emulated cell lane: differential conductance decode plus noise, times row voltage.
module xbar_cell #(
    parameter int VW = 8,
    parameter int GW = 6,
    localparam int EW = GW + 2,
    localparam int PW = VW + EW
) (
    input  logic signed [VW-1:0]   v,
    input  logic        [3*GW-1:0] word,
    input  logic                   active,
    output logic signed [PW-1:0]   prod
);

    logic signed [EW-1:0] g_pos;
    logic signed [EW-1:0] g_neg;
    logic signed [EW-1:0] noise;
    logic signed [EW-1:0] eff;
    logic signed [PW-1:0] v_x;
    logic signed [PW-1:0] eff_x;

    // R3: lane field layout {pos, neg, noise}
    assign g_pos = EW'({2'b00, word[3*GW-1:2*GW]});
    assign g_neg = EW'({2'b00, word[2*GW-1:GW]});
    assign noise = EW'($signed(word[GW-1:0]));
    assign eff   = g_pos - g_neg + noise;

    assign v_x   = PW'(v);
    assign eff_x = PW'(eff);

    // R4: padding lanes behave as zero-conductance cells
    assign prod  = active ? (v_x * eff_x) : '0;

endmodule

// File: rtl/xbar_adder_tree.sv
// Balanced reduction of the K lane products into one partial sum.
module xbar_adder_tree #(
    parameter int K  = 4,
    parameter int IW = 16,
    localparam int LV = (K > 1) ? $clog2(K) : 0,
    localparam int NP = 1 << LV,
    localparam int OW = IW + LV
) (
    input  logic signed [IW-1:0] in_v [K],
    output logic signed [OW-1:0] sum
);

    logic signed [OW-1:0] node [2*NP-1];

    for (genvar li = 0; li < NP; li++) begin : g_leaf
        if (li < K) begin : g_used
            assign node[NP-1+li] = OW'(in_v[li]);
        end else begin : g_pad
            assign node[NP-1+li] = '0;
        end
    end

    for (genvar ni = 0; ni < NP - 1; ni++) begin : g_node
        assign node[ni] = node[2*ni+1] + node[2*ni+2];
    end

    assign sum = node[0];

endmodule

// File: rtl/xbar_out_stage.sv
// Output decode: scale, saturate to result range, optional rectifier.
module xbar_out_stage #(
    parameter int AW = 32,
    parameter int SW = 16,
    localparam int MW = AW + SW + 1
) (
    input  logic signed [AW-1:0] acc,
    input  logic        [SW-1:0] scale,
    input  logic                 relu_en,
    output logic signed [AW-1:0] res
);

    logic signed [MW-1:0] prod;
    logic signed [AW-1:0] sat;
    logic                 fits;

    assign prod = MW'(acc) * MW'($signed({1'b0, scale}));
    assign fits = (&prod[MW-1:AW-1]) || !(|prod[MW-1:AW-1]);

    always_comb begin
        if (fits) begin
            sat = prod[AW-1:0];
        end else if (prod[MW-1]) begin
            sat = {1'b1, {(AW-1){1'b0}}};
        end else begin
            sat = {1'b0, {(AW-1){1'b1}}};
        end
    end

    assign res = (relu_en && sat[AW-1]) ? '0 : sat;

endmodule

// File: rtl/xbar_mvm_engine.sv
module xbar_mvm_engine
    import xbar_pkg::*;
#(
    parameter int N  = 6,
    parameter int K  = 4,
    parameter int VW = 8,
    parameter int GW = 6,
    parameter int SW = 16,
    localparam int PASSES = (N + K - 1) / K,
    localparam int LANEW  = 3 * GW,
    localparam int PW     = VW + GW + 2,
    localparam int AW     = 2 * PW,
    localparam int LV     = (K > 1) ? $clog2(K) : 0,
    localparam int TW     = PW + LV,
    localparam int XW     = AW + 2,
    localparam int ADW    = (N * PASSES > 1) ? $clog2(N * PASSES) : 1,
    localparam int CW     = (N > 1) ? $clog2(N + 1) : 1,
    localparam int PCW    = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   relu_en,
    input  logic [SW-1:0]          scale,
    output logic                   busy,
    input  logic                   vec_valid,
    input  logic [VW-1:0]          vec_data,
    output logic                   vec_ready,
    output logic                   mem_req,
    output logic [ADW-1:0]         mem_addr,
    input  logic [K*LANEW-1:0]     mem_rdata,
    output logic                   out_valid,
    output logic [AW-1:0]          out_data,
    output logic                   out_last
);

    localparam logic [CW-1:0]  LAST_ROW  = CW'(N - 1);
    localparam logic [PCW-1:0] LAST_PASS = PCW'(PASSES - 1);

    xbar_state_e state, state_n;

    logic signed [VW-1:0]  vreg [N];
    logic [CW-1:0]         ld_idx;
    logic [CW-1:0]         col;
    logic [PCW-1:0]        pass;
    logic [ADW-1:0]        addr_q;
    logic signed [AW-1:0]  acc;
    logic signed [AW-1:0]  acc_next;
    logic signed [AW-1:0]  acc_base;
    logic signed [XW-1:0]  acc_wide;
    logic                  relu_q;
    logic [SW-1:0]         scale_q;

    logic signed [VW-1:0]  lane_v   [K];
    logic                  lane_act [K];
    logic signed [PW-1:0]  lane_p   [K];
    logic signed [TW-1:0]  tree_sum;
    logic signed [AW-1:0]  res;

    logic last_pass;
    logic last_col;

    assign last_pass = (pass == LAST_PASS);
    assign last_col  = (col == LAST_ROW);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start) state_n = ST_LOAD;
            ST_LOAD:  if (vec_valid && ld_idx == LAST_ROW) state_n = ST_FETCH;
            ST_FETCH: state_n = ST_MAC;
            ST_MAC:   state_n = last_pass ? ST_EMIT : ST_FETCH;
            ST_EMIT:  state_n = last_col ? ST_IDLE : ST_FETCH;
            default:  state_n = ST_IDLE;
        endcase
    end

    // ---------------- lane selection (row voltages, padding) ----------------
    always_comb begin
        for (int i = 0; i < K; i++) begin
            if ((int'(pass) * K + i) < N) begin
                lane_act[i] = 1'b1;
                lane_v[i]   = vreg[CW'(int'(pass) * K + i)];
            end else begin
                lane_act[i] = 1'b0;
                lane_v[i]   = '0;
            end
        end
    end

    for (genvar gi = 0; gi < K; gi++) begin : g_lane
        xbar_cell #(
            .VW (VW),
            .GW (GW)
        ) u_cell (
            .v      (lane_v[gi]),
            .word   (mem_rdata[gi*LANEW +: LANEW]),
            .active (lane_act[gi]),
            .prod   (lane_p[gi])
        );
    end

    xbar_adder_tree #(
        .K  (K),
        .IW (PW)
    ) u_tree (
        .in_v (lane_p),
        .sum  (tree_sum)
    );

    // ---------------- saturating accumulator ----------------
    assign acc_base = (pass == '0) ? '0 : acc;
    assign acc_wide = XW'(acc_base) + XW'(tree_sum);

    always_comb begin
        if ((&acc_wide[XW-1:AW-1]) || !(|acc_wide[XW-1:AW-1])) begin
            acc_next = acc_wide[AW-1:0];
        end else if (acc_wide[XW-1]) begin
            acc_next = {1'b1, {(AW-1){1'b0}}};
        end else begin
            acc_next = {1'b0, {(AW-1){1'b1}}};
        end
    end

    xbar_out_stage #(
        .AW (AW),
        .SW (SW)
    ) u_out (
        .acc     (acc),
        .scale   (scale_q),
        .relu_en (relu_q),
        .res     (res)
    );

    // ---------------- datapath and registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_idx    <= '0;
            col       <= '0;
            pass      <= '0;
            addr_q    <= '0;
            acc       <= '0;
            relu_q    <= 1'b0;
            scale_q   <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
            for (int i = 0; i < N; i++) vreg[i] <= '0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        relu_q  <= relu_en;
                        scale_q <= scale;
                        ld_idx  <= '0;
                        col     <= '0;
                        pass    <= '0;
                        addr_q  <= '0;
                    end
                end
                ST_LOAD: begin
                    if (vec_valid) begin
                        vreg[ld_idx] <= vec_data;
                        ld_idx       <= ld_idx + 1'b1;
                    end
                end
                ST_FETCH: begin
                end
                ST_MAC: begin
                    acc    <= acc_next;
                    addr_q <= addr_q + 1'b1;
                    pass   <= last_pass ? '0 : pass + 1'b1;
                end
                ST_EMIT: begin
                    out_valid <= 1'b1;
                    out_data  <= res;
                    out_last  <= last_col;
                    col       <= col + 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign vec_ready = (state == ST_LOAD);
    assign mem_req   = (state == ST_FETCH);
    assign mem_addr  = addr_q;

endmodule

// File: rtl/xbar_mvm_checker.sv
module xbar_mvm_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          vec_ready,
    input logic          mem_req,
    input logic          out_valid,
    input logic          out_last,
    input logic [AW-1:0] out_data,
    input logic          relu_q
);

    assert_load_fetch_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_ready && mem_req));

    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_relu_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && relu_q) |-> !out_data[AW-1]);

    assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_last_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_done_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_last);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !vec_ready));

endmodule

bind xbar_mvm_engine xbar_mvm_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .vec_ready (vec_ready),
    .mem_req   (mem_req),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_data  (out_data),
    .relu_q    (relu_q)
);

// File: tb/xbar_mvm_engine_test.sv
module xbar_mvm_engine_test;

    localparam int N      = 6;
    localparam int K      = 4;
    localparam int VW     = 8;
    localparam int GW     = 6;
    localparam int SW     = 16;
    localparam int P      = (N + K - 1) / K;
    localparam int LANEW  = 3 * GW;
    localparam int AW     = 2 * (VW + GW + 2);
    localparam int ADW    = $clog2(N * P);
    localparam int WORDS  = N * P;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              relu_en = 1'b0;
    logic [SW-1:0]     scale = '0;
    logic              busy;
    logic              vec_valid = 1'b0;
    logic [VW-1:0]     vec_data = '0;
    logic              vec_ready;
    logic              mem_req;
    logic [ADW-1:0]    mem_addr;
    logic [K*LANEW-1:0] mem_rdata = '0;
    logic              out_valid;
    logic [AW-1:0]     out_data;
    logic              out_last;

    int checks = 0;
    int errors = 0;

    logic [K*LANEW-1:0] mem [WORDS];
    logic signed [VW-1:0] tv [N];
    int exp_addr = 0;
    int rd_cnt = 0;
    int last_cnt = 0;
    logic mon_on = 1'b0;

    always #5 clk = ~clk;

    xbar_mvm_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .relu_en(relu_en), .scale(scale),
        .busy(busy), .vec_valid(vec_valid), .vec_data(vec_data), .vec_ready(vec_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // read monitor: address order (R2) and reads per column
    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_req) begin
                check(int'(mem_addr) == exp_addr, "R2 address", longint'(mem_addr), longint'(exp_addr));
                exp_addr++;
            end
            if (out_valid) begin
                last_cnt = rd_cnt;
                rd_cnt = mem_req ? 1 : 0;
            end else if (mem_req) begin
                rd_cnt++;
            end
        end
    end

    function automatic longint cell_val(input int c, input int r);
        logic [K*LANEW-1:0] w;
        logic [LANEW-1:0]   f;
        longint gp, gn, nz;
        w  = mem[c * P + r / K];
        f  = w[(r % K) * LANEW +: LANEW];
        gp = longint'(f[3*GW-1:2*GW]);
        gn = longint'(f[2*GW-1:GW]);
        nz = longint'($signed(f[GW-1:0]));
        return gp - gn + nz;
    endfunction

    function automatic longint expect_col(input int c, input longint sc, input bit relu);
        longint s, m, hi, lo;
        s = 0;
        for (int r = 0; r < N; r++) s += longint'(tv[r]) * cell_val(c, r);
        m  = s * sc;
        hi = (longint'(1) <<< (AW - 1)) - 1;
        lo = -(longint'(1) <<< (AW - 1));
        if (m > hi) m = hi;
        if (m < lo) m = lo;
        if (relu && m < 0) m = 0;
        return m;
    endfunction

    task automatic run_mvm(input longint sc, input bit relu, input bit poke_start, input bit gaps, input string tag);
        int waitc;
        longint expv, act;
        exp_addr = 0;
        rd_cnt = 0;
        @(negedge clk);
        scale = SW'(sc);
        relu_en = relu;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R1: loading phase
        check(vec_ready == 1'b1, "R1 ready after start", longint'(vec_ready), 1);
        for (int i = 0; i < N; i++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                vec_valid = 1'b0;
                @(negedge clk);
            end
            vec_valid = 1'b1;
            vec_data  = tv[i];
            @(negedge clk);
        end
        vec_valid = 1'b0;
        check(vec_ready == 1'b0, "R1 ready drops after N", longint'(vec_ready), 0);
        relu_en = ~relu;
        scale = ~scale;
        for (int c = 0; c < N; c++) begin
            waitc = 0;
            do begin
                @(negedge clk);
                #1;
                waitc++;
                if (poke_start && c == 2 && waitc == 2) start = 1'b1;
                else start = 1'b0;
            end while (!out_valid && waitc < 200);
            start = 1'b0;
            expv = expect_col(c, sc, relu);
            act  = longint'($signed(out_data));
            check(out_valid && act == expv, $sformatf("R5 %s col %0d", tag, c), act, expv);
            check(out_last == (c == N - 1), "R8 last flag", longint'(out_last), longint'(c == N - 1));
            check(last_cnt == P, "R2 reads per column", longint'(last_cnt), longint'(P));
            if (c == N - 1) check(busy == 1'b0, "R8 busy falls with last", longint'(busy), 0);
        end
        repeat (3) @(negedge clk);
        if (poke_start) begin
            check(busy == 1'b0 && vec_ready == 1'b0, "R9 start while busy ignored",
                  longint'({busy, vec_ready}), 0);
        end
    endtask

    task automatic fill_random();
        for (int w = 0; w < WORDS; w++) mem[w] = {$urandom, $urandom, $urandom};
    endtask

    task automatic fill_const(input logic [LANEW-1:0] lane);
        for (int w = 0; w < WORDS; w++) mem[w] = {K{lane}};
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int w = 0; w < WORDS; w++) mem[w] = '0;
        for (int i = 0; i < N; i++) tv[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy == 1'b0 && vec_ready == 1'b0 && mem_req == 1'b0 && out_valid == 1'b0,
              "R10 reset outputs", longint'({busy, vec_ready, mem_req, out_valid}), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (2) @(negedge clk);

        // R3: one lane decode, pos=10 neg=3 noise=-2 -> 5; vector all 1 -> col sum 6*5
        fill_const({6'd10, 6'd3, 6'b111110});
        for (int i = 0; i < N; i++) tv[i] = 8'sd1;
        run_mvm(1, 1'b0, 1'b0, 1'b0, "R3 decode");

        // R6: positive and negative saturation; R7 rectifies saturated negative
        fill_const({6'd63, 6'd0, 6'd31});
        for (int i = 0; i < N; i++) tv[i] = 8'sd127;
        run_mvm(65535, 1'b0, 1'b0, 1'b0, "R6 sat+");
        for (int i = 0; i < N; i++) tv[i] = -8'sd128;
        run_mvm(65535, 1'b0, 1'b0, 1'b0, "R6 sat-");
        run_mvm(65535, 1'b1, 1'b0, 1'b0, "R7 relu sat");

        // R4: random memory in padded lanes; R5/R7/R9 random trials
        for (int t = 0; t < 10; t++) begin
            fill_random();
            for (int i = 0; i < N; i++) tv[i] = VW'($urandom);
            run_mvm((t % 4 == 3) ? 65535 : $urandom_range(0, 400), t[0], t == 5, t[1], "R4 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule